// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block caches recent virtual-page-to-physical-page translations in front of a page table walker. Every lookup presents a 20-bit virtual page number, a page offset and an access kind. All entries are compared in parallel. When a valid entry matches and grants the access, the physical address is produced combinationally in the same cycle. An entry that matches but forbids the access produces a protection fault instead. A lookup that finds no usable entry raises a walk request. The walker later answers with a fill that is installed for the retried access.

Each entry carries a valid flag, read, write and execute permissions, a dirty flag, the virtual page tag and the physical page number. A write to a writable but clean page is handled as a miss, so that the walker can mark the page dirty in memory. Writing the page-table base register empties the whole buffer. A single-page invalidate removes one translation after its table entry has been edited. Fills replace the least recently used entry, tracked by a per-entry age counter.

Top module: `tlbTop`

## Requirements
- R1: When a lookup matches a valid entry that permits the access and needs no dirty update, lkHit is 1 in the same cycle and lkPaddr equals the entry's physical page number concatenated above lkOffset.
- R2: Access kind codes are 0 = read (needs R), 1 = write (needs W), 2 or 3 = execute (needs X). A matching entry that lacks the needed permission gives lkFault = 1, with lkHit = 0 and no walk request.
- R3: A lookup with no usable entry and no walk outstanding raises walkReq in the same cycle, with walkVpn equal to lkVpn. While a walk is outstanding, no further walkReq is raised.
- R4: A write that matches a writable entry whose dirty flag is 0 is treated as a miss. The entry filled for that walk is stored dirty even if fillDirty is 0, and a write to it then hits.
- R5: fillValid while a walk is outstanding ends the walk and installs the entry, which is visible to lookups from the next cycle. fillValid with no walk outstanding is ignored.
- R6: baseWrite invalidates every entry, and lookups miss from the next cycle on.
- R7: invValid removes the entry whose tag equals invVpn. Other entries stay usable.
- R8: A fill in the same cycle as baseWrite or invValid is discarded. A fill that answers a walk during which baseWrite was asserted (including the cycle of the request) is discarded. In both cases the walk still ends.
- R9: A fill goes to the valid entry with the same tag if one exists, else to the lowest-numbered invalid entry, else to the least recently used entry. Hits and installs both count as uses.
- R10: After reset all entries are invalid and no walk is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup present this cycle |
| lkVpn | input | VPN_W | Virtual page number to translate |
| lkKind | input | 2 | Access kind: 0 read, 1 write, 2/3 execute |
| lkOffset | input | OFF_W | Byte offset within the page |
| lkHit | output | 1 | Translation available and permitted |
| lkFault | output | 1 | Matching entry forbids the access |
| lkPaddr | output | PPN_W+OFF_W | Physical address on a hit |
| walkReq | output | 1 | Start a page table walk |
| walkVpn | output | VPN_W | Page to walk |
| fillValid | input | 1 | Walker returns a translation |
| fillVpn | input | VPN_W | Tag of the returned translation |
| fillPpn | input | PPN_W | Physical page number returned |
| fillRd | input | 1 | Read permission returned |
| fillWr | input | 1 | Write permission returned |
| fillEx | input | 1 | Execute permission returned |
| fillDirty | input | 1 | Dirty flag returned |
| baseWrite | input | 1 | Page-table base register written |
| invValid | input | 1 | Invalidate one page |
| invVpn | input | VPN_W | Page to invalidate |

## Verification
The assertions assume the walker answers each request with one fill carrying the requested page. Under that assumption the buffer never holds two entries with the same tag, so a one-cycle-later check after a flush or an invalidate is meaningful. The random stimulus issues fills only while a walk is outstanding and always with the page that was requested. It draws lookup pages from a pool slightly larger than the buffer so that replacement occurs. The only stray fills are deliberate, directed ones that test the ignore rule.

// File: rtl/tlbPkg.sv
package tlbPkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_EXEC2 = 2'd3
  } accKind_t;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_LIVE  = 2'd1,
    WALK_STALE = 2'd2
  } walkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic flushAll;
    logic invOne;
    logic install;
    logic installDirty;
    logic touchHit;
  } tlbStrobe_t;
endpackage

// File: rtl/tlbLru.sv
module tlbLru #(
  parameter int ENTRIES = 16,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             touchEn,
  input  logic [IDX_W-1:0] touchIdx,
  output logic [IDX_W-1:0] victimIdx,
  output logic [ENTRIES-1:0] oldestVec
);
  localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] age [ENTRIES];
  logic [IDX_W-1:0] touchedAge;

  assign touchedAge = age[touchIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) age[i] <= IDX_W'(i);
    end else if (touchEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (IDX_W'(i) == touchIdx) age[i] <= '0;
        else if (age[i] < touchedAge) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : gOld
    assign oldestVec[g] = (age[g] == OLDEST);
  end

  always_comb begin
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (oldestVec[i]) victimIdx = IDX_W'(i);
  end
endmodule

// File: rtl/tlbCtrl.sv
module tlbCtrl import tlbPkg::*; (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lkValid,
  input  logic [1:0] lkKind,
  input  logic       anyMatch,
  input  logic       permOk,
  input  logic       dirtyOk,
  input  logic       baseWrite,
  input  logic       invValid,
  input  logic       fillValid,
  input  logic       fillDirty,
  output tlbStrobe_t strobe,
  output logic       lkHit,
  output logic       lkFault,
  output logic       walkReq
);
  walkState_t walkState;
  logic       pendWrite;
  logic       fillTaken;

  assign lkHit   = lkValid && anyMatch && permOk && dirtyOk;
  assign lkFault = lkValid && anyMatch && !permOk;
  assign walkReq = lkValid && !lkHit && !lkFault && (walkState == WALK_IDLE);

  assign fillTaken = fillValid && (walkState != WALK_IDLE);

  always_comb begin
    strobe.flushAll     = baseWrite;
    strobe.invOne       = invValid && !baseWrite;
    strobe.install      = fillTaken && (walkState == WALK_LIVE) && !baseWrite && !invValid;
    strobe.installDirty = fillDirty || pendWrite;
    strobe.touchHit     = lkHit && !strobe.install;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      walkState <= WALK_IDLE;
      pendWrite <= 1'b0;
    end else if (walkReq) begin
      walkState <= baseWrite ? WALK_STALE : WALK_LIVE;
      pendWrite <= (lkKind == ACC_WRITE);
    end else if (fillTaken) begin
      walkState <= WALK_IDLE;
      pendWrite <= 1'b0;
    end else if (walkState == WALK_LIVE && baseWrite) begin
      walkState <= WALK_STALE;
    end
  end
endmodule

// File: rtl/tlbData.sv
module tlbData import tlbPkg::*; #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tlbStrobe_t             strobe,
  input  logic [VPN_W-1:0]       lkVpn,
  input  logic [1:0]             lkKind,
  input  logic [OFF_W-1:0]       lkOffset,
  input  logic [VPN_W-1:0]       invVpn,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic                   fillRd,
  input  logic                   fillWr,
  input  logic                   fillEx,
  input  logic [IDX_W-1:0]       victimIdx,
  output logic                   anyMatch,
  output logic                   permOk,
  output logic                   dirtyOk,
  output logic [PPN_W+OFF_W-1:0] lkPaddr,
  output logic                   touchEn,
  output logic [IDX_W-1:0]       touchIdx
);
  logic [ENTRIES-1:0] vld, permR, permW, permX, dirty;
  logic [VPN_W-1:0]   vpnTag [ENTRIES];
  logic [PPN_W-1:0]   ppnArr [ENTRIES];

  logic [ENTRIES-1:0] matchVec, fillMatchVec, invMatchVec;
  logic [IDX_W-1:0]   hitIdx, fillIdx, freeIdx, installIdx;
  logic [PPN_W-1:0]   selPpn;
  logic               selR, selW, selX, selD;

  for (genvar g = 0; g < ENTRIES; g++) begin : gCmp
    assign matchVec[g]     = vld[g] && (vpnTag[g] == lkVpn);
    assign fillMatchVec[g] = vld[g] && (vpnTag[g] == fillVpn);
    assign invMatchVec[g]  = vld[g] && (vpnTag[g] == invVpn);
  end

  always_comb begin
    hitIdx = '0;
    selPpn = '0;
    selR = 1'b0; selW = 1'b0; selX = 1'b0; selD = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) begin
        hitIdx = IDX_W'(i);
        selPpn = selPpn | ppnArr[i];
        selR   = selR | permR[i];
        selW   = selW | permW[i];
        selX   = selX | permX[i];
        selD   = selD | dirty[i];
      end
    end
  end

  assign anyMatch = |matchVec;

  always_comb begin
    case (accKind_t'(lkKind))
      ACC_READ:  permOk = selR;
      ACC_WRITE: permOk = selW;
      default:   permOk = selX;
    endcase
  end

  assign dirtyOk = (accKind_t'(lkKind) != ACC_WRITE) || selD;
  assign lkPaddr = anyMatch ? {selPpn, lkOffset} : '0;

  always_comb begin
    fillIdx = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (fillMatchVec[i]) fillIdx = IDX_W'(i);
      if (!vld[i])         freeIdx = IDX_W'(i);
    end
    if (|fillMatchVec)  installIdx = fillIdx;
    else if (!(&vld))   installIdx = freeIdx;
    else                installIdx = victimIdx;
  end

  assign touchEn  = strobe.install || strobe.touchHit;
  assign touchIdx = strobe.install ? installIdx : hitIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vld <= '0;
    end else if (strobe.flushAll) begin
      vld <= '0;
    end else if (strobe.invOne) begin
      vld <= vld & ~invMatchVec;
    end else if (strobe.install) begin
      vld[installIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.install) begin
      vpnTag[installIdx] <= fillVpn;
      ppnArr[installIdx] <= fillPpn;
      permR[installIdx]  <= fillRd;
      permW[installIdx]  <= fillWr;
      permX[installIdx]  <= fillEx;
      dirty[installIdx]  <= strobe.installDirty;
    end
  end
endmodule

// File: rtl/tlbTop.sv
module tlbTop import tlbPkg::*; #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   lkValid,
  input  logic [VPN_W-1:0]       lkVpn,
  input  logic [1:0]             lkKind,
  input  logic [OFF_W-1:0]       lkOffset,
  output logic                   lkHit,
  output logic                   lkFault,
  output logic [PPN_W+OFF_W-1:0] lkPaddr,
  output logic                   walkReq,
  output logic [VPN_W-1:0]       walkVpn,
  input  logic                   fillValid,
  input  logic [VPN_W-1:0]       fillVpn,
  input  logic [PPN_W-1:0]       fillPpn,
  input  logic                   fillRd,
  input  logic                   fillWr,
  input  logic                   fillEx,
  input  logic                   fillDirty,
  input  logic                   baseWrite,
  input  logic                   invValid,
  input  logic [VPN_W-1:0]       invVpn
);
  localparam int IDX_W = $clog2(ENTRIES);

  tlbStrobe_t         strobe;
  logic               anyMatch, permOk, dirtyOk, touchEn;
  logic [IDX_W-1:0]   touchIdx, victimIdx;
  logic [ENTRIES-1:0] oldestVec;

  assign walkVpn = lkVpn;

  tlbCtrl ctrl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkKind(lkKind),
    .anyMatch(anyMatch), .permOk(permOk), .dirtyOk(dirtyOk),
    .baseWrite(baseWrite), .invValid(invValid), .fillValid(fillValid),
    .fillDirty(fillDirty), .strobe(strobe), .lkHit(lkHit),
    .lkFault(lkFault), .walkReq(walkReq)
  );

  tlbData #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lkVpn(lkVpn), .lkKind(lkKind),
    .lkOffset(lkOffset), .invVpn(invVpn), .fillVpn(fillVpn), .fillPpn(fillPpn),
    .fillRd(fillRd), .fillWr(fillWr), .fillEx(fillEx), .victimIdx(victimIdx),
    .anyMatch(anyMatch), .permOk(permOk), .dirtyOk(dirtyOk), .lkPaddr(lkPaddr),
    .touchEn(touchEn), .touchIdx(touchIdx)
  );

  tlbLru #(.ENTRIES(ENTRIES)) lru (
    .clk(clk), .rstN(rstN), .touchEn(touchEn), .touchIdx(touchIdx),
    .victimIdx(victimIdx), .oldestVec(oldestVec)
  );
endmodule

// File: rtl/tlbCheck.sv
module tlbCheck #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20
) (
  input logic               clk,
  input logic               rstN,
  input logic               lkValid,
  input logic [VPN_W-1:0]   lkVpn,
  input logic               lkHit,
  input logic               lkFault,
  input logic               walkReq,
  input logic               baseWrite,
  input logic               invValid,
  input logic [VPN_W-1:0]   invVpn,
  input logic [ENTRIES-1:0] oldestVec
);
  assert_hit_xor_fault_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(lkHit && lkFault));

  assert_one_walk_R3: assert property (@(posedge clk) disable iff (!rstN)
    walkReq |=> !walkReq);

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    baseWrite |=> !lkHit);

  assert_inv_removes_R7: assert property (@(posedge clk) disable iff (!rstN)
    invValid |=> !(lkValid && lkHit && lkVpn == $past(invVpn)));

  assert_single_oldest_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones(oldestVec) == 1);
endmodule

bind tlbTop tlbCheck #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) chk (.*);

// File: tb/tlbTop_test.sv
`timescale 1ns/1ps
module tlbTop_test;
  localparam int ENTRIES = 16;
  localparam int VPN_W = 20, PPN_W = 20, OFF_W = 12;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN, lkValid, fillValid, fillRd, fillWr, fillEx, fillDirty, baseWrite, invValid;
  logic [VPN_W-1:0] lkVpn, fillVpn, invVpn, walkVpn;
  logic [1:0] lkKind;
  logic [OFF_W-1:0] lkOffset;
  logic [PPN_W-1:0] fillPpn;
  logic lkHit, lkFault, walkReq;
  logic [PPN_W+OFF_W-1:0] lkPaddr;

  tlbTop #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .OFF_W(OFF_W)) uut (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkVpn(lkVpn), .lkKind(lkKind),
    .lkOffset(lkOffset), .lkHit(lkHit), .lkFault(lkFault), .lkPaddr(lkPaddr),
    .walkReq(walkReq), .walkVpn(walkVpn), .fillValid(fillValid), .fillVpn(fillVpn),
    .fillPpn(fillPpn), .fillRd(fillRd), .fillWr(fillWr), .fillEx(fillEx),
    .fillDirty(fillDirty), .baseWrite(baseWrite), .invValid(invValid), .invVpn(invVpn)
  );

  // reference model
  logic             mV [ENTRIES];
  logic [VPN_W-1:0] mTag [ENTRIES];
  logic [PPN_W-1:0] mPpn [ENTRIES];
  logic             mR [ENTRIES], mW [ENTRIES], mX [ENTRIES], mD [ENTRIES];
  int               mAge [ENTRIES];
  logic             mPend, mStale, mPendWr;
  logic [VPN_W-1:0] mPendVpn;

  int nChecks = 0, nFails = 0;
  logic gotHit, gotWalk, gotFault;

  function automatic int findIdx(logic [VPN_W-1:0] v);
    for (int i = 0; i < ENTRIES; i++) if (mV[i] && mTag[i] == v) return i;
    return -1;
  endfunction

  function automatic logic permFor(int i, logic [1:0] k);
    if (k == 2'd0) return mR[i];
    if (k == 2'd1) return mW[i];
    return mX[i];
  endfunction

  function automatic int pickSlot(logic [VPN_W-1:0] v);
    int s;
    s = findIdx(v);
    if (s >= 0) return s;
    for (int i = 0; i < ENTRIES; i++) if (!mV[i]) return i;
    for (int i = 0; i < ENTRIES; i++) if (mAge[i] == ENTRIES - 1) return i;
    return 0;
  endfunction

  task automatic touch(int k);
    int a;
    a = mAge[k];
    for (int i = 0; i < ENTRIES; i++) if (mAge[i] < a) mAge[i]++;
    mAge[k] = 0;
  endtask

  task automatic modelReset();
    for (int i = 0; i < ENTRIES; i++) begin mV[i] = 0; mAge[i] = i; end
    mPend = 0; mStale = 0; mPendWr = 0; mPendVpn = '0;
  endtask

  task automatic check1(string req, string ctx, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s [%s] %s actual=%0h expected=%0h", req, ctx, what, act, exp);
    end
  endtask

  task automatic setIdle();
    lkValid = 0; lkVpn = '0; lkKind = 2'd0; lkOffset = '0;
    fillValid = 0; fillVpn = '0; fillPpn = '0; fillRd = 0; fillWr = 0; fillEx = 0; fillDirty = 0;
    baseWrite = 0; invValid = 0; invVpn = '0;
  endtask

  // inputs are set at a falling edge; outputs checked 1 ns later; model advances at the rising edge
  task automatic step(string ctx);
    int m, slot;
    logic eHit, eFault, eWalk, ok, accept;
    #1;
    m = findIdx(lkVpn);
    ok = (m >= 0) ? permFor(m, lkKind) : 1'b0;
    eHit   = lkValid && m >= 0 && ok && !(lkKind == 2'd1 && !mD[m]);
    eFault = lkValid && m >= 0 && !ok;
    eWalk  = lkValid && !eHit && !eFault && !mPend;
    check1("R1", ctx, "lkHit", 64'(lkHit), 64'(eHit));
    check1("R2", ctx, "lkFault", 64'(lkFault), 64'(eFault));
    check1("R3", ctx, "walkReq", 64'(walkReq), 64'(eWalk));
    if (eHit) check1("R1", ctx, "lkPaddr", 64'(lkPaddr), 64'({mPpn[m], lkOffset}));
    if (eWalk) check1("R3", ctx, "walkVpn", 64'(walkVpn), 64'(lkVpn));
    gotHit = lkHit; gotWalk = walkReq; gotFault = lkFault;
    @(posedge clk);
    accept = fillValid && mPend && !mStale && !baseWrite && !invValid;
    slot = pickSlot(fillVpn);
    if (baseWrite) begin
      for (int i = 0; i < ENTRIES; i++) mV[i] = 0;
    end else if (invValid) begin
      for (int i = 0; i < ENTRIES; i++) if (mV[i] && mTag[i] == invVpn) mV[i] = 0;
    end else if (accept) begin
      mV[slot] = 1; mTag[slot] = fillVpn; mPpn[slot] = fillPpn;
      mR[slot] = fillRd; mW[slot] = fillWr; mX[slot] = fillEx; mD[slot] = fillDirty | mPendWr;
    end
    if (accept) touch(slot);
    else if (eHit) touch(m);
    if (eWalk) begin
      mPend = 1; mStale = baseWrite; mPendWr = (lkKind == 2'd1); mPendVpn = lkVpn;
    end else if (fillValid && mPend) begin
      mPend = 0; mStale = 0; mPendWr = 0;
    end else if (mPend && baseWrite) begin
      mStale = 1;
    end
    @(negedge clk);
  endtask

  task automatic look(logic [VPN_W-1:0] v, logic [1:0] k, string ctx);
    setIdle(); lkValid = 1; lkVpn = v; lkKind = k; lkOffset = OFF_W'($urandom);
    step(ctx);
  endtask

  task automatic fill(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, logic r, logic w, logic x, logic d, string ctx);
    setIdle(); fillValid = 1; fillVpn = v; fillPpn = p; fillRd = r; fillWr = w; fillEx = x; fillDirty = d;
    step(ctx);
  endtask

  task automatic install(logic [VPN_W-1:0] v, logic [PPN_W-1:0] p, string ctx);
    look(v, 2'd0, ctx);
    fill(v, p, 1, 1, 1, 1, ctx);
  endtask

  bit finished = 0;
  initial begin
    #(100000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4410));
    setIdle();
    rstN = 0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1;

    // R10: empty after reset
    look(20'h00005, 2'd0, "R10 reset empty");
    check1("R10", "reset empty", "walkReq", 64'(gotWalk), 64'd1);
    fill(20'h00005, 20'hABCDE, 1, 0, 0, 0, "R5 fill read-only");
    look(20'h00005, 2'd0, "R1 read hit");
    check1("R5", "installed entry", "lkHit", 64'(gotHit), 64'd1);
    look(20'h00005, 2'd1, "R2 write to read-only");
    check1("R2", "write read-only", "lkFault", 64'(gotFault), 64'd1);
    look(20'h00005, 2'd2, "R2 exec to read-only");

    // R5 stray fill ignored
    fill(20'h00077, 20'h11111, 1, 1, 1, 1, "R5 stray fill");
    look(20'h00077, 2'd0, "R5 stray fill ignored");
    check1("R5", "stray ignored", "walkReq", 64'(gotWalk), 64'd1);
    look(20'h00078, 2'd0, "R3 no second walk");
    fill(20'h00077, 20'h11111, 1, 1, 1, 1, "R5 answer");

    // R4 dirty upgrade
    look(20'h00030, 2'd0, "R4 prep");
    fill(20'h00030, 20'h22222, 1, 1, 0, 0, "R4 clean fill");
    look(20'h00030, 2'd1, "R4 write to clean");
    check1("R4", "write clean", "walkReq", 64'(gotWalk), 64'd1);
    fill(20'h00030, 20'h22222, 1, 1, 0, 0, "R4 refill with dirty 0");
    look(20'h00030, 2'd1, "R4 write after refill");
    check1("R4", "write after refill", "lkHit", 64'(gotHit), 64'd1);

    // R7 invalidate one
    setIdle(); invValid = 1; invVpn = 20'h00030; step("R7 invalidate");
    look(20'h00030, 2'd0, "R7 removed page misses");
    fill(20'h00030, 20'h22223, 1, 1, 1, 1, "R7 refill");
    look(20'h00077, 2'd0, "R7 other page kept");
    check1("R7", "other page kept", "lkHit", 64'(gotHit), 64'd1);

    // R8 fill same cycle as invalidate; fill after base change
    look(20'h00040, 2'd0, "R8 walk");
    setIdle(); fillValid = 1; fillVpn = 20'h00040; fillPpn = 20'h3; fillRd = 1;
    invValid = 1; invVpn = 20'h00999; step("R8 fill with invalidate");
    look(20'h00040, 2'd0, "R8 fill dropped");
    check1("R8", "fill with invalidate", "walkReq", 64'(gotWalk), 64'd1);
    setIdle(); baseWrite = 1; step("R6 R8 base change during walk");
    fill(20'h00040, 20'h4, 1, 1, 1, 1, "R8 stale fill");
    look(20'h00040, 2'd0, "R8 stale dropped");
    check1("R8", "stale fill", "lkHit", 64'(gotHit), 64'd0);
    fill(20'h00040, 20'h4, 1, 1, 1, 1, "R8 fresh fill");

    // R6 flush
    install(20'h00050, 20'h5, "R6 prep");
    setIdle(); baseWrite = 1; step("R6 flush");
    look(20'h00050, 2'd0, "R6 after flush");
    check1("R6", "after flush", "lkHit", 64'(gotHit), 64'd0);
    fill(20'h00050, 20'h5, 1, 1, 1, 1, "R6 refill");

    // R9 replacement order
    setIdle(); baseWrite = 1; step("R9 flush");
    for (int i = 0; i < ENTRIES; i++) install(VPN_W'(32'h100 + i), PPN_W'(32'h800 + i), "R9 fill all");
    look(20'h00100, 2'd0, "R9 touch first");
    install(20'h00200, 20'h900, "R9 evict oldest");
    look(20'h00100, 2'd0, "R9 recent kept");
    check1("R9", "recent kept", "lkHit", 64'(gotHit), 64'd1);
    look(20'h00101, 2'd0, "R9 oldest evicted");
    check1("R9", "oldest evicted", "walkReq", 64'(gotWalk), 64'd1);
    fill(20'h00101, 20'h901, 1, 1, 1, 1, "R9 refill");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int r;
      setIdle();
      r = $urandom % 100;
      if (r < 70) begin
        lkValid = 1; lkVpn = VPN_W'($urandom % 24); lkKind = 2'($urandom); lkOffset = OFF_W'($urandom);
      end
      if (mPend && ($urandom % 100) < 40) begin
        fillValid = 1; fillVpn = mPendVpn; fillPpn = PPN_W'($urandom);
        fillRd = ($urandom % 8) != 0; fillWr = ($urandom % 3) != 0;
        fillEx = ($urandom % 2) != 0; fillDirty = ($urandom % 2) != 0;
      end
      if (($urandom % 100) < 2) baseWrite = 1;
      if (($urandom % 100) < 5) begin invValid = 1; invVpn = VPN_W'($urandom % 24); end
      step("random");
    end

    setIdle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule